// File: doc/BRIEF.md
# Codec Global Register Command Decoder

This block sits behind the byte-level control port of a multi-channel telephony codec. It acts on the small set of registers that are shared by all channels. The byte deserialiser in front of it hands over whole bytes with a valid flag. A frame-start marker flags the first byte of each transaction as the command. The next valid byte without the marker is the data byte.

Reads are answered as soon as the command byte is accepted, so the reply is ready for the data-byte slot. Writes act when the data byte arrives. The shared write commands are the no-operation, the interrupt clear, the local-register reset and the full-reset equivalent. These four are honoured only when their data byte is all ones; any other data byte cancels them with no effect. The full-reset equivalent also clears the chopper clock selection register. The register holds a 2-bit secondary select and a 4-bit primary select, which feed the chopper clock generators.

Top module: `codec_greg_decoder`

## Requirements
- R1: A valid byte with `frame_start_i` high is a command. The next valid byte with `frame_start_i` low is its data byte, even with idle cycles between them. A second frame start before the data byte drops the first command. A data byte with no pending command has no effect.
- R2: A read command 20H makes `rd_valid_o` high for one cycle with `rd_data_o` = 01H, in the cycle after the command byte is accepted.
- R3: A read command 24H returns {2'b00, secondary[1:0], primary[3:0]}: bits 5..4 hold the secondary select, bits 3..0 the primary select, and bits 7..6 read 0.
- R4: Write command A4H loads data bits 5..4 into the secondary select and bits 3..0 into the primary select, and drops bits 7..6. The new value shows on the select outputs in the cycle after the data byte is accepted.
- R5: Command A1H followed by data FFH pulses `irq_clear_o` for one cycle, in the cycle after the data byte is accepted.
- R6: Command A2H followed by FFH pulses `local_reset_o` for one cycle and leaves the clock selection unchanged.
- R7: Command A3H followed by FFH pulses `global_reset_o` for one cycle and sets both selects to 0 in that same cycle.
- R8: Command A0H followed by FFH changes no output.
- R9: Commands A0H to A3H followed by any data byte other than FFH change no output.
- R10: A read command other than 20H and 24H returns 00H with `rd_valid_o`. A write command other than A0H to A4H changes no output.
- R11: While `rst_n` is low at a clock edge, both selects, all strobes, `rd_valid_o` and `rd_data_o` become 0, and any pending command is dropped.
- R12: At most one of the three strobes is high in any cycle, and none stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_valid_i | input | 1 | Byte on `byte_i` is valid this cycle |
| frame_start_i | input | 1 | Valid byte is a command byte |
| byte_i | input | 8 | Incoming command or data byte |
| rd_valid_o | output | 1 | One-cycle flag: read reply on `rd_data_o` |
| rd_data_o | output | 8 | Read reply byte, held until the next read |
| irq_clear_o | output | 1 | One-cycle strobe: clear line-interface interrupts |
| local_reset_o | output | 1 | One-cycle strobe: reset per-channel registers |
| global_reset_o | output | 1 | One-cycle strobe: full-reset equivalent |
| chop_sec_sel_o | output | 2 | Secondary chopper clock select |
| chop_pri_sel_o | output | 4 | Primary chopper clock select |

## Verification
On every cycle the assertions check that the strobes are exclusive and last one cycle. They check that the selects are zero whenever the full-reset strobe fires, and that a local reset leaves the selects unchanged. They check that a version read or a selection read-back returns the right byte one cycle after the command, and that a cancelled strobe command (data not FFH) produces no strobe. Only the bench scenarios show the field positions of an A4H write, the dropping of a command cut off by a new frame start, stray data bytes, unknown commands, and the state after a mid-run reset.

// File: rtl/gcd_pkg.sv
// Package: command codes and the decoded action type shared by the
// global register decoder. Assumes 8-bit command and data bytes.
package gcd_pkg;
    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] CMD_VER_RD  = 8'h20;
    localparam logic [BYTE_W-1:0] CMD_CSEL_RD = 8'h24;
    localparam logic [BYTE_W-1:0] CMD_NOP_WR  = 8'hA0;
    localparam logic [BYTE_W-1:0] CMD_IRQ_WR  = 8'hA1;
    localparam logic [BYTE_W-1:0] CMD_SRST_WR = 8'hA2;
    localparam logic [BYTE_W-1:0] CMD_HRST_WR = 8'hA3;
    localparam logic [BYTE_W-1:0] CMD_CSEL_WR = 8'hA4;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_NOP,
        ACT_IRQ,
        ACT_SRST,
        ACT_HRST,
        ACT_CSEL
    } act_e;
endpackage

// File: rtl/gcd_framer.sv
// Framer: pairs each command byte with the next data byte.
// Assumes frame_start is only meaningful together with byte_valid.
// Emits a one-cycle command event and a one-cycle pair event.
module gcd_framer #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_valid_i,
    input  logic          frame_start_i,
    input  logic [BW-1:0] byte_i,
    output logic          cmd_evt_o,
    output logic          pair_evt_o,
    output logic [BW-1:0] pair_cmd_o
);
    logic          armed_q;
    logic [BW-1:0] cmd_q;

    assign cmd_evt_o  = byte_valid_i && frame_start_i;
    assign pair_evt_o = byte_valid_i && !frame_start_i && armed_q;
    assign pair_cmd_o = cmd_q;

    // Hold the latest command until its data byte arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            cmd_q   <= '0;
        end else if (cmd_evt_o) begin
            armed_q <= 1'b1;
            cmd_q   <= byte_i;
        end else if (pair_evt_o) begin
            armed_q <= 1'b0;
        end
    end
endmodule

// File: rtl/gcd_action_decode.sv
// Action decoder: turns a command/data pair into one action.
// Purely combinational. Strobe commands need an all-ones data byte.
module gcd_action_decode
    import gcd_pkg::*;
#(
    parameter int BW = 8
) (
    input  logic          pair_evt_i,
    input  logic [BW-1:0] cmd_i,
    input  logic [BW-1:0] data_i,
    output act_e          act_o
);
    localparam logic [BW-1:0] ALL_ONES = {BW{1'b1}};

    logic data_ok;
    assign data_ok = (data_i == ALL_ONES);

    // Map the pair onto an action; anything else is ignored.
    always_comb begin
        act_o = ACT_NONE;
        if (pair_evt_i) begin
            case (cmd_i)
                CMD_NOP_WR:  act_o = data_ok ? ACT_NOP  : ACT_NONE;
                CMD_IRQ_WR:  act_o = data_ok ? ACT_IRQ  : ACT_NONE;
                CMD_SRST_WR: act_o = data_ok ? ACT_SRST : ACT_NONE;
                CMD_HRST_WR: act_o = data_ok ? ACT_HRST : ACT_NONE;
                CMD_CSEL_WR: act_o = ACT_CSEL;
                default:     act_o = ACT_NONE;
            endcase
        end
    end
endmodule

// File: rtl/gcd_csel_reg.sv
// Chopper clock selection register. The write takes the low SEC_W+PRI_W
// data bits and drops the rest. The full-reset action clears it.
module gcd_csel_reg #(
    parameter int BW    = 8,
    parameter int SEC_W = 2,
    parameter int PRI_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic             clr_i,
    input  logic [BW-1:0]    data_i,
    output logic [SEC_W-1:0] sec_o,
    output logic [PRI_W-1:0] pri_o
);
    localparam int FLD_W = SEC_W + PRI_W;

    logic [FLD_W-1:0] fld_q;

    // Load, clear or hold the selection fields.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            fld_q <= '0;
        end else if (wr_i) begin
            fld_q <= data_i[FLD_W-1:0];
        end
    end

    assign sec_o = fld_q[FLD_W-1:PRI_W];
    assign pri_o = fld_q[PRI_W-1:0];
endmodule

// File: rtl/gcd_reply.sv
// Read reply: on a read command, registers the addressed byte.
// Reserved and unknown positions read 0. Write commands are ignored.
module gcd_reply
    import gcd_pkg::*;
#(
    parameter int          BW      = 8,
    parameter int          SEC_W   = 2,
    parameter int          PRI_W   = 4,
    parameter logic [BW-1:0] VERSION = 8'h01
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_evt_i,
    input  logic [BW-1:0]    cmd_i,
    input  logic [SEC_W-1:0] sec_i,
    input  logic [PRI_W-1:0] pri_i,
    output logic             rd_valid_o,
    output logic [BW-1:0]    rd_data_o
);
    localparam int FLD_W = SEC_W + PRI_W;

    logic [BW-1:0] csel_word;
    logic [BW-1:0] lookup;

    // Place the fields in the low bits; the reserved bits above stay 0.
    generate
        if (BW > FLD_W) begin : g_pad
            assign csel_word = {{(BW-FLD_W){1'b0}}, sec_i, pri_i};
        end else begin : g_nopad
            assign csel_word = BW'({sec_i, pri_i});
        end
    endgenerate

    // Select the reply byte for the addressed register.
    always_comb begin
        case (cmd_i)
            CMD_VER_RD:  lookup = VERSION;
            CMD_CSEL_RD: lookup = csel_word;
            default:     lookup = '0;
        endcase
    end

    // Register the reply and flag it for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_o <= 1'b0;
            rd_data_o  <= '0;
        end else begin
            rd_valid_o <= 1'b0;
            if (cmd_evt_i && !cmd_i[BW-1]) begin
                rd_valid_o <= 1'b1;
                rd_data_o  <= lookup;
            end
        end
    end
endmodule

// File: rtl/codec_greg_decoder.sv
// Top: global register command decoder. Takes framed bytes and drives
// read replies, one-cycle strobes and the chopper clock selects.
// Assumes a byte deserialiser in front that supplies whole bytes.
module codec_greg_decoder
    import gcd_pkg::*;
#(
    parameter int            SEC_W   = 2,
    parameter int            PRI_W   = 4,
    parameter logic [7:0]    VERSION = 8'h01
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_valid_i,
    input  logic             frame_start_i,
    input  logic [7:0]       byte_i,
    output logic             rd_valid_o,
    output logic [7:0]       rd_data_o,
    output logic             irq_clear_o,
    output logic             local_reset_o,
    output logic             global_reset_o,
    output logic [SEC_W-1:0] chop_sec_sel_o,
    output logic [PRI_W-1:0] chop_pri_sel_o
);
    logic          cmd_evt;
    logic          pair_evt;
    logic [7:0]    pair_cmd;
    act_e          act;

    gcd_framer #(.BW(BYTE_W)) u_framer (
        .clk          (clk),
        .rst_n        (rst_n),
        .byte_valid_i (byte_valid_i),
        .frame_start_i(frame_start_i),
        .byte_i       (byte_i),
        .cmd_evt_o    (cmd_evt),
        .pair_evt_o   (pair_evt),
        .pair_cmd_o   (pair_cmd)
    );

    gcd_action_decode #(.BW(BYTE_W)) u_decode (
        .pair_evt_i(pair_evt),
        .cmd_i     (pair_cmd),
        .data_i    (byte_i),
        .act_o     (act)
    );

    gcd_csel_reg #(.BW(BYTE_W), .SEC_W(SEC_W), .PRI_W(PRI_W)) u_csel (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_i  (act == ACT_CSEL),
        .clr_i (act == ACT_HRST),
        .data_i(byte_i),
        .sec_o (chop_sec_sel_o),
        .pri_o (chop_pri_sel_o)
    );

    gcd_reply #(.BW(BYTE_W), .SEC_W(SEC_W), .PRI_W(PRI_W), .VERSION(VERSION)) u_reply (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_evt_i (cmd_evt),
        .cmd_i     (byte_i),
        .sec_i     (chop_sec_sel_o),
        .pri_i     (chop_pri_sel_o),
        .rd_valid_o(rd_valid_o),
        .rd_data_o (rd_data_o)
    );

    // Register the one-cycle strobes from the decoded action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_clear_o    <= 1'b0;
            local_reset_o  <= 1'b0;
            global_reset_o <= 1'b0;
        end else begin
            irq_clear_o    <= (act == ACT_IRQ);
            local_reset_o  <= (act == ACT_SRST);
            global_reset_o <= (act == ACT_HRST);
        end
    end
endmodule

// File: rtl/codec_greg_decoder_chk.sv
// Checker for codec_greg_decoder, attached by bind. Watches ports only.
module codec_greg_decoder_chk #(
    parameter int SEC_W = 2,
    parameter int PRI_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             byte_valid_i,
    input logic             frame_start_i,
    input logic [7:0]       byte_i,
    input logic             rd_valid_o,
    input logic [7:0]       rd_data_o,
    input logic             irq_clear_o,
    input logic             local_reset_o,
    input logic             global_reset_o,
    input logic [SEC_W-1:0] chop_sec_sel_o,
    input logic [PRI_W-1:0] chop_pri_sel_o
);
    // R12: strobes are mutually exclusive
    a_r12_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_clear_o, local_reset_o, global_reset_o}));

    // R12: no strobe lasts two cycles
    a_r12_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clear_o || local_reset_o || global_reset_o) |=>
        !(irq_clear_o || local_reset_o || global_reset_o));

    // R7: the full-reset strobe coincides with cleared selects
    a_r7_hrst_clears: assert property (@(posedge clk) disable iff (!rst_n)
        global_reset_o |-> (chop_sec_sel_o == '0 && chop_pri_sel_o == '0));

    // R6: a local reset leaves the selects unchanged
    a_r6_srst_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        local_reset_o |-> ($stable(chop_sec_sel_o) && $stable(chop_pri_sel_o)));

    // R2: version read answers 01H on the next cycle
    a_r2_version: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid_i && frame_start_i && byte_i == 8'h20) |=>
        (rd_valid_o && rd_data_o == 8'h01));

    // R3: selection read-back with zero reserved bits
    a_r3_csel_read: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid_i && frame_start_i && byte_i == 8'h24) |=>
        (rd_valid_o && rd_data_o[7:6] == 2'b00 &&
         rd_data_o[5:4] == chop_sec_sel_o && rd_data_o[3:0] == chop_pri_sel_o));

    // R9: a data byte other than FFH after a strobe command gives no strobe.
    // The framer holds the command; track it here from the ports.
    logic       held_v;
    logic [7:0] held_c;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_v <= 1'b0;
            held_c <= '0;
        end else if (byte_valid_i && frame_start_i) begin
            held_v <= 1'b1;
            held_c <= byte_i;
        end else if (byte_valid_i) begin
            held_v <= 1'b0;
        end
    end

    a_r9_bad_data_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (held_v && byte_valid_i && !frame_start_i && held_c[7:2] == 6'b101000 &&
         byte_i != 8'hFF) |=> !(irq_clear_o || local_reset_o || global_reset_o));
endmodule

bind codec_greg_decoder codec_greg_decoder_chk #(.SEC_W(SEC_W), .PRI_W(PRI_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .byte_valid_i  (byte_valid_i),
    .frame_start_i (frame_start_i),
    .byte_i        (byte_i),
    .rd_valid_o    (rd_valid_o),
    .rd_data_o     (rd_data_o),
    .irq_clear_o   (irq_clear_o),
    .local_reset_o (local_reset_o),
    .global_reset_o(global_reset_o),
    .chop_sec_sel_o(chop_sec_sel_o),
    .chop_pri_sel_o(chop_pri_sel_o)
);

// File: tb/tb_codec_greg_decoder.sv
// Bench for codec_greg_decoder: a vector table walked by one loop,
// then directed tests for framing, stray bytes and reset.
module tb_codec_greg_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_valid_i = 1'b0;
    logic       frame_start_i = 1'b0;
    logic [7:0] byte_i = '0;
    logic       rd_valid_o;
    logic [7:0] rd_data_o;
    logic       irq_clear_o, local_reset_o, global_reset_o;
    logic [1:0] chop_sec_sel_o;
    logic [3:0] chop_pri_sel_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    codec_greg_decoder dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .byte_valid_i  (byte_valid_i),
        .frame_start_i (frame_start_i),
        .byte_i        (byte_i),
        .rd_valid_o    (rd_valid_o),
        .rd_data_o     (rd_data_o),
        .irq_clear_o   (irq_clear_o),
        .local_reset_o (local_reset_o),
        .global_reset_o(global_reset_o),
        .chop_sec_sel_o(chop_sec_sel_o),
        .chop_pri_sel_o(chop_pri_sel_o)
    );

    // Vector: cmd, data, read?, expected reply, expected strobes
    // {global,local,irq}, expected selects {sec,pri}, requirement number.
    typedef struct packed {
        logic [7:0] cmd;
        logic [7:0] data;
        logic       rd;
        logic [7:0] rd_exp;
        logic [2:0] stb_exp;
        logic [5:0] sel_exp;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{8'h20, 8'h00, 1'b1, 8'h01, 3'b000, 6'h00, 8'd2},  // R2 version
        '{8'h24, 8'h00, 1'b1, 8'h00, 3'b000, 6'h00, 8'd3},  // R3 default 0
        '{8'hA4, 8'hFF, 1'b0, 8'h00, 3'b000, 6'h3F, 8'd4},  // R4 bits 7..6 dropped
        '{8'h24, 8'h00, 1'b1, 8'h3F, 3'b000, 6'h3F, 8'd3},  // R3 reserved read 0
        '{8'hA4, 8'h5A, 1'b0, 8'h00, 3'b000, 6'h1A, 8'd4},  // R4 sec=01 pri=1010
        '{8'h24, 8'h00, 1'b1, 8'h1A, 3'b000, 6'h1A, 8'd3},  // R3
        '{8'hA1, 8'hFF, 1'b0, 8'h00, 3'b001, 6'h1A, 8'd5},  // R5 irq clear
        '{8'hA1, 8'h7F, 1'b0, 8'h00, 3'b000, 6'h1A, 8'd9},  // R9
        '{8'hA2, 8'hFF, 1'b0, 8'h00, 3'b010, 6'h1A, 8'd6},  // R6 local reset
        '{8'hA2, 8'hFE, 1'b0, 8'h00, 3'b000, 6'h1A, 8'd9},  // R9
        '{8'hA0, 8'hFF, 1'b0, 8'h00, 3'b000, 6'h1A, 8'd8},  // R8 no-op
        '{8'h2F, 8'h00, 1'b1, 8'h00, 3'b000, 6'h1A, 8'd10}, // R10 unknown read
        '{8'h85, 8'hFF, 1'b0, 8'h00, 3'b000, 6'h1A, 8'd10}, // R10 unknown write
        '{8'hA3, 8'h00, 1'b0, 8'h00, 3'b000, 6'h1A, 8'd9},  // R9
        '{8'hA3, 8'hFF, 1'b0, 8'h00, 3'b100, 6'h00, 8'd7},  // R7 full reset
        '{8'h24, 8'h00, 1'b1, 8'h00, 3'b000, 6'h00, 8'd7}   // R7 selects cleared
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] stb();
        return {global_reset_o, local_reset_o, irq_clear_o};
    endfunction

    task automatic drive(input logic v, input logic s, input logic [7:0] b);
        @(negedge clk);
        byte_valid_i  = v;
        frame_start_i = s;
        byte_i        = b;
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        for (int i = 0; i < WATCHDOG; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R11: reset state
        drive(1'b0, 1'b0, 8'h00);
        @(negedge clk);
        @(negedge clk);
        check("R11 rd_valid", 16'(rd_valid_o), 16'h0);
        check("R11 rd_data", 16'(rd_data_o), 16'h0);
        check("R11 strobes", 16'(stb()), 16'h0);
        check("R11 selects", 16'({chop_sec_sel_o, chop_pri_sel_o}), 16'h0);
        rst_n = 1'b1;

        // Table walk: command, data, then one idle cycle.
        for (int i = 0; i < NV; i++) begin
            drive(1'b1, 1'b1, VECS[i].cmd);
            drive(1'b1, 1'b0, VECS[i].data);   // samples after command edge
            check($sformatf("R%0d rd_valid v%0d", VECS[i].req, i), 16'(rd_valid_o), 16'(VECS[i].rd));
            if (VECS[i].rd)
                check($sformatf("R%0d rd_data v%0d", VECS[i].req, i), 16'(rd_data_o), 16'(VECS[i].rd_exp));
            drive(1'b0, 1'b0, 8'h00);
            check($sformatf("R%0d strobes v%0d", VECS[i].req, i), 16'(stb()), 16'(VECS[i].stb_exp));
            check($sformatf("R%0d selects v%0d", VECS[i].req, i),
                  16'({chop_sec_sel_o, chop_pri_sel_o}), 16'(VECS[i].sel_exp));
            @(negedge clk);
            check($sformatf("R12 strobe drop v%0d", i), 16'(stb()), 16'h0);
        end

        // R1: idle gap between command and data still pairs.
        drive(1'b1, 1'b1, 8'hA4);
        drive(1'b0, 1'b0, 8'h00);
        drive(1'b0, 1'b0, 8'h00);
        drive(1'b1, 1'b0, 8'h25);
        drive(1'b0, 1'b0, 8'h00);
        check("R1 gap pairing", 16'({chop_sec_sel_o, chop_pri_sel_o}), 16'h25);

        // R1: a new frame start drops the pending A1H.
        drive(1'b1, 1'b1, 8'hA1);
        drive(1'b1, 1'b1, 8'h20);
        drive(1'b1, 1'b0, 8'hFF);
        check("R1 restart reply", 16'({rd_valid_o, rd_data_o}), 16'h101);
        drive(1'b0, 1'b0, 8'h00);
        check("R1 restart no strobe", 16'(stb()), 16'h0);

        // R1: a stray data byte with no pending command does nothing.
        drive(1'b1, 1'b0, 8'hFF);
        drive(1'b0, 1'b0, 8'h00);
        check("R1 stray byte", 16'({stb(), chop_sec_sel_o, chop_pri_sel_o}), 16'h25);

        // R11: reset mid-run with a pending A3H command.
        drive(1'b1, 1'b1, 8'hA3);
        drive(1'b0, 1'b0, 8'h00);
        rst_n = 1'b0;
        @(negedge clk);
        check("R11 mid reset selects", 16'({chop_sec_sel_o, chop_pri_sel_o}), 16'h0);
        rst_n = 1'b1;
        drive(1'b1, 1'b0, 8'hFF);
        drive(1'b0, 1'b0, 8'h00);
        check("R11 pending dropped", 16'(stb()), 16'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule